// File: doc/BRIEF.md
# Register Producer-Tag Rename Table

This block holds the architectural register values of an out-of-order core together with a producer tag for each register. A tag of zero means the stored value is current. A nonzero tag names the reservation station that will deliver the next value for that register. When an instruction issues, the table is read on two source ports. Each port returns either a usable value or the tag that the consumer must wait for. In the same cycle the table writes the issuing station's tag against the destination register. This renames the register, so any later writer can issue without waiting on older readers or older writers.

The table also watches the result bus. When a station broadcasts a result, every register still waiting on that station's tag takes the value and becomes ready. A register whose tag has since been replaced by a younger writer ignores the broadcast, so stale results never land. Tag zero is reserved and is never treated as a producer. The reservation stations and the execution units sit outside this block.

Top module: `rename_table`

## Requirements
- R1: While reset is asserted, and just after it is released, every register reads with tag 0, ready high and value 0.
- R2: A read port returns the selected register's tag, its value, and ready = 1 exactly when that tag is 0.
- R3: A rename (valid, nonzero tag) writes the tag into the destination register, replacing any earlier tag. The new tag is visible on the read ports from the next cycle.
- R4: A broadcast whose nonzero tag equals a register's tag writes the broadcast value into that register and clears its tag. The update is visible from the next cycle.
- R5: A broadcast whose tag differs from a register's tag leaves that register's tag and value unchanged. This covers a result from a writer that a later rename has superseded.
- R6: The read ports show the state as it was before the current cycle's edge. A source read of the register being renamed in the same issue sees the old tag and value.
- R7: If a rename and a matching broadcast hit the same register in one cycle, the register takes the new rename tag and keeps its old value.
- R8: One broadcast resolves every register that holds its tag.
- R9: A rename carrying tag 0 and a broadcast carrying tag 0 are both ignored.
- R10: The two read ports are independent and may select the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_addr | input | AW | Register selected by source port A |
| rd_a_ready | output | 1 | Port A value is current (tag is 0) |
| rd_a_tag | output | TAG_W | Port A producer tag |
| rd_a_value | output | DATA_W | Port A stored value |
| rd_b_addr | input | AW | Register selected by source port B |
| rd_b_ready | output | 1 | Port B value is current (tag is 0) |
| rd_b_tag | output | TAG_W | Port B producer tag |
| rd_b_value | output | DATA_W | Port B stored value |
| ren_valid | input | 1 | Destination rename request |
| ren_reg | input | AW | Destination register to rename |
| ren_tag | input | TAG_W | Tag of the issuing station |
| bus_valid | input | 1 | Result bus carries a result |
| bus_tag | input | TAG_W | Tag of the producing station |
| bus_value | input | DATA_W | Result value |

## Verification
Two functions can land in the same cycle: a rename of a destination register and a broadcast that matches that register's current tag. The bench provokes this by renaming a pending register with a fresh tag while the old producer's tag is on the bus. In the following cycle it expects the register to show the new tag, ready low and the old value. A later broadcast of the new tag must then resolve the register normally. A second same-cycle collision, a source read of the register being renamed, is judged by expecting the old state on the read port.

// File: rtl/rt_pkg.sv
package rt_pkg;

    // Per-entry update decision taken each cycle.
    typedef enum logic [1:0] {
        UPD_HOLD    = 2'd0,
        UPD_RENAME  = 2'd1,
        UPD_RESOLVE = 2'd2
    } upd_e;

endpackage

// File: rtl/rt_entry_ctl.sv
module rt_entry_ctl #(
    parameter int TAG_W = 4
) (
    input  logic [TAG_W-1:0] cur_tag,
    input  logic             ren_hit,
    input  logic             bus_valid,
    input  logic [TAG_W-1:0] bus_tag,
    output rt_pkg::upd_e     upd
);

    // Rename has priority: a younger writer supersedes the broadcast.
    always_comb begin
        if (ren_hit) begin
            upd = rt_pkg::UPD_RENAME;
        end else if (bus_valid && (bus_tag != '0) && (cur_tag == bus_tag)) begin
            upd = rt_pkg::UPD_RESOLVE;
        end else begin
            upd = rt_pkg::UPD_HOLD;
        end
    end

endmodule

// File: rtl/rt_read_port.sv
module rt_read_port #(
    parameter int NREG   = 16,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(NREG)
) (
    input  logic [NREG-1:0][TAG_W-1:0]  tags,
    input  logic [NREG-1:0][DATA_W-1:0] values,
    input  logic [AW-1:0]               addr,
    output logic                        ready,
    output logic [TAG_W-1:0]            tag,
    output logic [DATA_W-1:0]           value
);

    assign tag   = tags[addr];
    assign value = values[addr];
    assign ready = (tags[addr] == '0);

endmodule

// File: rtl/rename_table.sv
module rename_table #(
    parameter int NREG   = 16,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rd_a_addr,
    output logic              rd_a_ready,
    output logic [TAG_W-1:0]  rd_a_tag,
    output logic [DATA_W-1:0] rd_a_value,
    input  logic [AW-1:0]     rd_b_addr,
    output logic              rd_b_ready,
    output logic [TAG_W-1:0]  rd_b_tag,
    output logic [DATA_W-1:0] rd_b_value,
    input  logic              ren_valid,
    input  logic [AW-1:0]     ren_reg,
    input  logic [TAG_W-1:0]  ren_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_value
);

    typedef struct packed {
        logic [NREG-1:0][TAG_W-1:0]  tag;
        logic [NREG-1:0][DATA_W-1:0] value;
    } table_t;

    table_t       st_d;
    table_t       st_q;
    rt_pkg::upd_e upd [NREG];

    logic ren_ok;
    assign ren_ok = ren_valid && (ren_tag != '0);

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        logic hit;
        assign hit = ren_ok && (ren_reg == AW'(g));
        rt_entry_ctl #(.TAG_W(TAG_W)) u_ctl (
            .cur_tag   (st_q.tag[g]),
            .ren_hit   (hit),
            .bus_valid (bus_valid),
            .bus_tag   (bus_tag),
            .upd       (upd[g])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            case (upd[i])
                rt_pkg::UPD_RENAME: begin
                    st_d.tag[i] = ren_tag;
                end
                rt_pkg::UPD_RESOLVE: begin
                    st_d.tag[i]   = '0;
                    st_d.value[i] = bus_value;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    rt_read_port #(.NREG(NREG), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_port_a (
        .tags   (st_q.tag),
        .values (st_q.value),
        .addr   (rd_a_addr),
        .ready  (rd_a_ready),
        .tag    (rd_a_tag),
        .value  (rd_a_value)
    );

    rt_read_port #(.NREG(NREG), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_port_b (
        .tags   (st_q.tag),
        .values (st_q.value),
        .addr   (rd_b_addr),
        .ready  (rd_b_ready),
        .tag    (rd_b_tag),
        .value  (rd_b_value)
    );

endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
    parameter int NREG   = 16,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(NREG)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     rd_a_addr,
    input logic              rd_a_ready,
    input logic [TAG_W-1:0]  rd_a_tag,
    input logic [DATA_W-1:0] rd_a_value,
    input logic              ren_valid,
    input logic [AW-1:0]     ren_reg,
    input logic [TAG_W-1:0]  ren_tag,
    input logic              bus_valid,
    input logic [TAG_W-1:0]  bus_tag,
    input logic [DATA_W-1:0] bus_value
);

    logic a_ren_hit;
    logic a_bus_hit;
    assign a_ren_hit = ren_valid && (ren_tag != '0) && (ren_reg == rd_a_addr);
    assign a_bus_hit = bus_valid && (bus_tag != '0) && (rd_a_tag == bus_tag);

    a_r3_rename_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_tag != '0) |=>
            (rd_a_addr != $past(ren_reg) || rd_a_tag == $past(ren_tag)));

    a_r4_bus_resolves: assert property (@(posedge clk) disable iff (!rst_n)
        (a_bus_hit && !a_ren_hit) |=>
            (rd_a_addr != $past(rd_a_addr) ||
             (rd_a_ready && rd_a_value == $past(bus_value))));

    a_r5_unhit_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_bus_hit && !a_ren_hit) |=>
            (rd_a_addr != $past(rd_a_addr) ||
             (rd_a_tag == $past(rd_a_tag) && rd_a_value == $past(rd_a_value))));

    a_r7_rename_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (a_bus_hit && a_ren_hit) |=>
            (rd_a_addr != $past(rd_a_addr) ||
             (!rd_a_ready && rd_a_tag == $past(ren_tag) &&
              rd_a_value == $past(rd_a_value))));

endmodule

bind rename_table rt_checker #(.NREG(NREG), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_rt_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_a_addr  (rd_a_addr),
    .rd_a_ready (rd_a_ready),
    .rd_a_tag   (rd_a_tag),
    .rd_a_value (rd_a_value),
    .ren_valid  (ren_valid),
    .ren_reg    (ren_reg),
    .ren_tag    (ren_tag),
    .bus_valid  (bus_valid),
    .bus_tag    (bus_tag),
    .bus_value  (bus_value)
);

// File: tb/test_rename_table.sv
module test_rename_table;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_addr = '0, rd_b_addr = '0;
    logic        rd_a_ready, rd_b_ready;
    logic [3:0]  rd_a_tag, rd_b_tag;
    logic [31:0] rd_a_value, rd_b_value;
    logic        ren_valid = 1'b0;
    logic [3:0]  ren_reg = '0, ren_tag = '0;
    logic        bus_valid = 1'b0;
    logic [3:0]  bus_tag = '0;
    logic [31:0] bus_value = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rename_table i_rename_table (
        .clk(clk), .rst_n(rst_n),
        .rd_a_addr(rd_a_addr), .rd_a_ready(rd_a_ready), .rd_a_tag(rd_a_tag), .rd_a_value(rd_a_value),
        .rd_b_addr(rd_b_addr), .rd_b_ready(rd_b_ready), .rd_b_tag(rd_b_tag), .rd_b_value(rd_b_value),
        .ren_valid(ren_valid), .ren_reg(ren_reg), .ren_tag(ren_tag),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value)
    );

    typedef struct packed {
        logic [3:0]  ra;
        logic [3:0]  rb;
        logic        rv;
        logic [3:0]  rr;
        logic [3:0]  rt;
        logic        bv;
        logic [3:0]  bt;
        logic [31:0] bd;
        logic        ea_r;
        logic [3:0]  ea_t;
        logic [31:0] ea_v;
        logic        eb_r;
        logic [3:0]  eb_t;
        logic [31:0] eb_v;
    } vec_t;

    // Expected read values are the state before the vector's own edge.
    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{4'd1, 4'd2, 1'b1, 4'd1, 4'd3, 1'b0, 4'd0, 32'h0,    1'b1, 4'd0, 32'h0,    1'b1, 4'd0, 32'h0},
        '{4'd1, 4'd3, 1'b1, 4'd3, 4'd5, 1'b0, 4'd0, 32'h0,    1'b0, 4'd3, 32'h0,    1'b1, 4'd0, 32'h0},
        '{4'd1, 4'd3, 1'b0, 4'd0, 4'd0, 1'b1, 4'd3, 32'hAAAA, 1'b0, 4'd3, 32'h0,    1'b0, 4'd5, 32'h0},
        '{4'd1, 4'd3, 1'b0, 4'd0, 4'd0, 1'b1, 4'd7, 32'hBEEF, 1'b1, 4'd0, 32'hAAAA, 1'b0, 4'd5, 32'h0},
        '{4'd1, 4'd3, 1'b1, 4'd1, 4'd2, 1'b0, 4'd0, 32'h0,    1'b1, 4'd0, 32'hAAAA, 1'b0, 4'd5, 32'h0},
        '{4'd1, 4'd3, 1'b1, 4'd1, 4'd4, 1'b0, 4'd0, 32'h0,    1'b0, 4'd2, 32'hAAAA, 1'b0, 4'd5, 32'h0},
        '{4'd1, 4'd3, 1'b0, 4'd0, 4'd0, 1'b1, 4'd2, 32'h2222, 1'b0, 4'd4, 32'hAAAA, 1'b0, 4'd5, 32'h0},
        '{4'd1, 4'd3, 1'b0, 4'd0, 4'd0, 1'b1, 4'd4, 32'h4444, 1'b0, 4'd4, 32'hAAAA, 1'b0, 4'd5, 32'h0},
        '{4'd1, 4'd3, 1'b1, 4'd3, 4'd6, 1'b1, 4'd5, 32'h5555, 1'b1, 4'd0, 32'h4444, 1'b0, 4'd5, 32'h0},
        '{4'd3, 4'd1, 1'b0, 4'd0, 4'd0, 1'b1, 4'd6, 32'h6666, 1'b0, 4'd6, 32'h0,    1'b1, 4'd0, 32'h4444},
        '{4'd3, 4'd7, 1'b1, 4'd7, 4'd0, 1'b0, 4'd0, 32'h0,    1'b1, 4'd0, 32'h6666, 1'b1, 4'd0, 32'h0},
        '{4'd7, 4'd3, 1'b0, 4'd0, 4'd0, 1'b1, 4'd0, 32'h9999, 1'b1, 4'd0, 32'h0,    1'b1, 4'd0, 32'h6666},
        '{4'd7, 4'd0, 1'b1, 4'd7, 4'd1, 1'b0, 4'd0, 32'h0,    1'b1, 4'd0, 32'h0,    1'b1, 4'd0, 32'h0},
        '{4'd7, 4'd0, 1'b1, 4'd0, 4'd1, 1'b0, 4'd0, 32'h0,    1'b0, 4'd1, 32'h0,    1'b1, 4'd0, 32'h0},
        '{4'd7, 4'd0, 1'b0, 4'd0, 4'd0, 1'b1, 4'd1, 32'h7777, 1'b0, 4'd1, 32'h0,    1'b0, 4'd1, 32'h0},
        '{4'd7, 4'd0, 1'b0, 4'd0, 4'd0, 1'b0, 4'd0, 32'h0,    1'b1, 4'd0, 32'h7777, 1'b1, 4'd0, 32'h7777}
    };

    function automatic string vreq(int i);
        case (i)
            0:       return "R1 R6";
            1:       return "R3 R2";
            2:       return "R3";
            3:       return "R4 R5";
            4:       return "R5";
            5:       return "R3";
            6, 7:    return "R5";
            8:       return "R4";
            9:       return "R7";
            10:      return "R4 R7";
            11, 12:  return "R9";
            13:      return "R3";
            14:      return "R8";
            default: return "R8 R4";
        endcase
    endfunction

    task automatic chk(string req, string port, logic r, logic [3:0] t, logic [31:0] v,
                       logic er, logic [3:0] et, logic [31:0] ev);
        checks++;
        if (r !== er || t !== et || v !== ev) begin
            failures++;
            $display("FAIL %s port %s: got ready=%0b tag=%0d value=%h, expected ready=%0b tag=%0d value=%h",
                     req, port, r, t, v, er, et, ev);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state visible during reset
        rd_a_addr = 4'd5; rd_b_addr = 4'd15;
        #2;
        chk("R1", "A", rd_a_ready, rd_a_tag, rd_a_value, 1'b1, 4'd0, 32'h0);
        chk("R1", "B", rd_b_ready, rd_b_tag, rd_b_value, 1'b1, 4'd0, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            rd_a_addr = VEC[i].ra;  rd_b_addr = VEC[i].rb;
            ren_valid = VEC[i].rv;  ren_reg   = VEC[i].rr; ren_tag = VEC[i].rt;
            bus_valid = VEC[i].bv;  bus_tag   = VEC[i].bt; bus_value = VEC[i].bd;
            #2;
            chk(vreq(i), "A", rd_a_ready, rd_a_tag, rd_a_value, VEC[i].ea_r, VEC[i].ea_t, VEC[i].ea_v);
            chk(vreq(i), "B", rd_b_ready, rd_b_tag, rd_b_value, VEC[i].eb_r, VEC[i].eb_t, VEC[i].eb_v);
            @(negedge clk);
        end

        // R10: both ports select the same register
        ren_valid = 1'b0; bus_valid = 1'b0;
        rd_a_addr = 4'd7; rd_b_addr = 4'd7;
        #2;
        chk("R10", "A", rd_a_ready, rd_a_tag, rd_a_value, 1'b1, 4'd0, 32'h7777);
        chk("R10", "B", rd_b_ready, rd_b_tag, rd_b_value, 1'b1, 4'd0, 32'h7777);
        @(negedge clk);

        // R3 then R1: rename pending, then reset clears it
        ren_valid = 1'b1; ren_reg = 4'd5; ren_tag = 4'd9;
        @(negedge clk);
        ren_valid = 1'b0;
        rd_a_addr = 4'd5;
        #2;
        chk("R3", "A", rd_a_ready, rd_a_tag, rd_a_value, 1'b0, 4'd9, 32'h0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R1", "A", rd_a_ready, rd_a_tag, rd_a_value, 1'b1, 4'd0, 32'h0);
        chk("R1", "B", rd_b_ready, rd_b_tag, rd_b_value, 1'b1, 4'd0, 32'h0);
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(20 * 10000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule